// File: doc/BRIEF.md
# Two-Buffer Tile Handoff Controller

This block coordinates two engines that share a pair of tile buffers. A producer engine completes tiles one at a time into one buffer while a consumer engine works from the other, so tile N is filled while tile N-1 is being consumed. Each buffer has a ready flag. The producer raises a buffer's flag when it reports a finished tile. The consumer's input latch may take a buffer only while that buffer's flag is up, and taking it lowers the flag. The tile data itself never passes through the block; only the control handshake does.

Both sides walk the buffers in strict alternation, starting at buffer 0 after reset. When the producer's next buffer still holds a tile the consumer has not taken, the producer is stalled and any completion it reports is ignored. A starvation timer counts how long the consumer has been asking for a tile that is not there. It raises a sticky error once a programmable limit is reached. Software or a neighbouring engine clears the error with a clear pulse.

The controller is built from four state machines. The producer machine has states PR_FILL_A and PR_FILL_B, one for each target buffer; an accepted completion moves it to the other state. The consumer machine has states CN_TAKE_A and CN_TAKE_B, one for each source buffer; a latch moves it to the other state. The timer machine has three states. TM_IDLE: the consumer is not waiting. TM_RUN: counting wait cycles. TM_HELD: the limit has been reached in the current wait. It goes TM_IDLE to TM_RUN on the first wait cycle, TM_RUN to TM_HELD when the limit is hit (or TM_IDLE straight to TM_HELD when the limit is 1), and any state back to TM_IDLE when the wait ends. The flag bank holds one set/clear register for each buffer.

Top module: `pp_sync_top`

## Requirements
- R1: After reset, both ready flags are 0, `prod_sel` and `cons_sel` are 0 (buffer 0), `prod_stall`, `cons_latch` and `starve_err` are 0.
- R2: A `prod_done` pulse while `prod_stall` is 0 sets bit `prod_sel` of `buf_ready` at the next clock edge, and `prod_sel` then toggles, giving the order 0,1,0,1,...
- R3: `prod_stall` equals bit `prod_sel` of `buf_ready`. A `prod_done` while stalled has no effect: the flags and `prod_sel` are unchanged.
- R4: `cons_latch` is 1 in a cycle exactly when `cons_req` is 1 and bit `cons_sel` of `buf_ready` is 1. It responds in the same cycle, with no register between the inputs and this output.
- R5: After a cycle with `cons_latch` at 1, bit `cons_sel` of `buf_ready` is 0 at the next edge and `cons_sel` toggles, giving the order 0,1,0,1,...
- R6: Both flags can be set at once (the producer runs one tile ahead), and the consumer then takes them in production order.
- R7: A wait cycle is one with `cons_req` 1 and bit `cons_sel` of `buf_ready` 0. With `wait_limit` = L > 0, `starve_err` rises at the edge that ends the L-th consecutive wait cycle. With L = 0, the timer never raises it.
- R8: A cycle that is not a wait cycle restarts the wait count. This includes the flag being set by the producer and `cons_req` dropping. Separate waits do not add up.
- R9: `starve_err` stays 1 until an `err_clr` cycle. If the limit is reached in the same cycle as `err_clr`, the error stays set. A wait that continues after the limit, once cleared, does not raise the error again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prod_done | input | 1 | Producer reports a finished tile in its current buffer |
| prod_sel | output | 1 | Buffer the producer must fill next |
| prod_stall | output | 1 | Producer target buffer still holds an untaken tile |
| cons_req | input | 1 | Consumer wants the next tile |
| cons_latch | output | 1 | Consumer latch enable for buffer `cons_sel` this cycle |
| cons_sel | output | 1 | Buffer the consumer reads next |
| buf_ready | output | 2 | Ready flag for each buffer (bit b = buffer b) |
| wait_limit | input | TW | Starvation limit in wait cycles; 0 disables |
| err_clr | input | 1 | Clears the sticky starvation error |
| starve_err | output | 1 | Sticky starvation error |

## Verification
The hardest situation to reach is the one where the starvation limit is hit in the same cycle as `err_clr`. It must be reached together with waits that are cut short one cycle before the limit by a late producer completion. The bench gets there with a sweep. For each of several limits, every 4-cycle pattern of producer-done and consumer-request bits is applied back to back, and the clear pulse runs on a period of 7 that is not linked to the pattern length. This way, limit hits, flag arrivals and clears fall on every relative phase. A bench-side model of the flags, pointers and wait count predicts every output in every cycle.

// File: rtl/pp_sync_pkg.sv
package pp_sync_pkg;

    localparam int NBUF = 2;

    typedef enum logic {
        PR_FILL_A = 1'b0,
        PR_FILL_B = 1'b1
    } prod_state_e;

    typedef enum logic {
        CN_TAKE_A = 1'b0,
        CN_TAKE_B = 1'b1
    } cons_state_e;

    typedef enum logic [1:0] {
        TM_IDLE = 2'd0,
        TM_RUN  = 2'd1,
        TM_HELD = 2'd2
    } tmr_state_e;

endpackage

// File: rtl/pp_flag_bank.sv
module pp_flag_bank
    import pp_sync_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NBUF-1:0] set_i,
    input  logic [NBUF-1:0] clr_i,
    output logic [NBUF-1:0] ready_o
);

    for (genvar b = 0; b < NBUF; b++) begin : g_flag
        logic flag_q;
        logic flag_d;

        // clear has priority over a set of the same flag
        always_comb begin
            flag_d = flag_q;
            if (set_i[b]) flag_d = 1'b1;
            if (clr_i[b]) flag_d = 1'b0;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) flag_q <= 1'b0;
            else        flag_q <= flag_d;
        end

        assign ready_o[b] = flag_q;
    end

endmodule

// File: rtl/pp_prod_fsm.sv
module pp_prod_fsm
    import pp_sync_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            done_i,
    input  logic [NBUF-1:0] ready_i,
    output logic            sel_o,
    output logic            stall_o,
    output logic [NBUF-1:0] set_o
);

    prod_state_e state_q;
    prod_state_e state_d;
    logic        accept;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PR_FILL_A: if (accept) state_d = PR_FILL_B;
            PR_FILL_B: if (accept) state_d = PR_FILL_A;
            default:   state_d = PR_FILL_A;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PR_FILL_A;
        else        state_q <= state_d;
    end

    always_comb begin
        sel_o   = 1'b0;
        stall_o = 1'b0;
        set_o   = '0;
        accept  = 1'b0;
        unique case (state_q)
            PR_FILL_A: begin
                sel_o    = 1'b0;
                stall_o  = ready_i[0];
                accept   = done_i && !ready_i[0];
                set_o[0] = accept;
            end
            PR_FILL_B: begin
                sel_o    = 1'b1;
                stall_o  = ready_i[1];
                accept   = done_i && !ready_i[1];
                set_o[1] = accept;
            end
            default: begin
                sel_o = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/pp_cons_fsm.sv
module pp_cons_fsm
    import pp_sync_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_i,
    input  logic [NBUF-1:0] ready_i,
    output logic            sel_o,
    output logic            latch_o,
    output logic [NBUF-1:0] clr_o,
    output logic            wait_o
);

    cons_state_e state_q;
    cons_state_e state_d;
    logic        take;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CN_TAKE_A: if (take) state_d = CN_TAKE_B;
            CN_TAKE_B: if (take) state_d = CN_TAKE_A;
            default:   state_d = CN_TAKE_A;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CN_TAKE_A;
        else        state_q <= state_d;
    end

    always_comb begin
        sel_o  = 1'b0;
        take   = 1'b0;
        wait_o = 1'b0;
        clr_o  = '0;
        unique case (state_q)
            CN_TAKE_A: begin
                sel_o    = 1'b0;
                take     = req_i && ready_i[0];
                wait_o   = req_i && !ready_i[0];
                clr_o[0] = take;
            end
            CN_TAKE_B: begin
                sel_o    = 1'b1;
                take     = req_i && ready_i[1];
                wait_o   = req_i && !ready_i[1];
                clr_o[1] = take;
            end
            default: begin
                sel_o = 1'b0;
            end
        endcase
        latch_o = take;
    end

endmodule

// File: rtl/pp_starve_timer.sv
module pp_starve_timer
    import pp_sync_pkg::*;
#(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wait_i,
    input  logic [TW-1:0] limit_i,
    input  logic          clr_i,
    output logic          err_o
);

    localparam logic [TW:0] ONE = {{TW{1'b0}}, 1'b1};

    tmr_state_e    state_q;
    tmr_state_e    state_d;
    logic [TW-1:0] cnt_q;
    logic [TW-1:0] cnt_d;
    logic          err_q;
    logic          trip;
    logic          armed;
    logic          at_limit;

    assign armed    = wait_i && (limit_i != '0);
    assign at_limit = (({1'b0, cnt_q} + ONE) == {1'b0, limit_i});

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TM_IDLE: begin
                if (armed) state_d = at_limit ? TM_HELD : TM_RUN;
            end
            TM_RUN: begin
                if (!armed)        state_d = TM_IDLE;
                else if (at_limit) state_d = TM_HELD;
            end
            TM_HELD: begin
                if (!wait_i) state_d = TM_IDLE;
            end
            default: state_d = TM_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TM_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        trip  = 1'b0;
        cnt_d = cnt_q;
        unique case (state_q)
            TM_IDLE: begin
                cnt_d = '0;
                if (armed) begin
                    trip  = at_limit;
                    cnt_d = at_limit ? '0 : cnt_q + 1'b1;
                end
            end
            TM_RUN: begin
                if (!armed) begin
                    cnt_d = '0;
                end else begin
                    trip  = at_limit;
                    cnt_d = at_limit ? '0 : cnt_q + 1'b1;
                end
            end
            TM_HELD: begin
                cnt_d = '0;
            end
            default: cnt_d = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            err_q <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            if (trip)       err_q <= 1'b1;
            else if (clr_i) err_q <= 1'b0;
        end
    end

    assign err_o = err_q;

endmodule

// File: rtl/pp_sync_top.sv
module pp_sync_top
    import pp_sync_pkg::*;
#(
    parameter int TW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            prod_done,
    output logic            prod_sel,
    output logic            prod_stall,
    input  logic            cons_req,
    output logic            cons_latch,
    output logic            cons_sel,
    output logic [NBUF-1:0] buf_ready,
    input  logic [TW-1:0]   wait_limit,
    input  logic            err_clr,
    output logic            starve_err
);

    logic [NBUF-1:0] set_req;
    logic [NBUF-1:0] clr_req;
    logic            cons_wait;

    pp_flag_bank flags_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (set_req),
        .clr_i   (clr_req),
        .ready_o (buf_ready)
    );

    pp_prod_fsm prod_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .done_i  (prod_done),
        .ready_i (buf_ready),
        .sel_o   (prod_sel),
        .stall_o (prod_stall),
        .set_o   (set_req)
    );

    pp_cons_fsm cons_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_i   (cons_req),
        .ready_i (buf_ready),
        .sel_o   (cons_sel),
        .latch_o (cons_latch),
        .clr_o   (clr_req),
        .wait_o  (cons_wait)
    );

    pp_starve_timer #(.TW(TW)) tmr_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wait_i  (cons_wait),
        .limit_i (wait_limit),
        .clr_i   (err_clr),
        .err_o   (starve_err)
    );

endmodule

// File: rtl/pp_sync_chk.sv
module pp_sync_chk #(
    parameter int TW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          prod_done,
    input logic          prod_sel,
    input logic          prod_stall,
    input logic          cons_req,
    input logic          cons_latch,
    input logic          cons_sel,
    input logic [1:0]    buf_ready,
    input logic [TW-1:0] wait_limit,
    input logic          err_clr,
    input logic          starve_err
);

    a_r2_alternate: assert property (@(posedge clk) disable iff (!rst_n)
        (prod_done && !prod_stall) |=> (prod_sel != $past(prod_sel)));

    a_r2_flag_raised: assert property (@(posedge clk) disable iff (!rst_n)
        (prod_done && !prod_stall) |=> buf_ready[$past(prod_sel)]);

    a_r3_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (prod_done && prod_stall) |=> $stable(prod_sel));

    a_r4_latch_gated: assert property (@(posedge clk) disable iff (!rst_n)
        cons_latch |-> (cons_req && buf_ready[cons_sel]));

    a_r5_latch_clears: assert property (@(posedge clk) disable iff (!rst_n)
        cons_latch |=> (!buf_ready[$past(cons_sel)] && (cons_sel != $past(cons_sel))));

    a_r5_sel_steady: assert property (@(posedge clk) disable iff (!rst_n)
        !cons_latch |=> $stable(cons_sel));

    a_r7_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (!starve_err && wait_limit == '0) |=> !starve_err);

    a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (starve_err && !err_clr) |=> starve_err);

endmodule

bind pp_sync_top pp_sync_chk #(.TW(TW)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .prod_done  (prod_done),
    .prod_sel   (prod_sel),
    .prod_stall (prod_stall),
    .cons_req   (cons_req),
    .cons_latch (cons_latch),
    .cons_sel   (cons_sel),
    .buf_ready  (buf_ready),
    .wait_limit (wait_limit),
    .err_clr    (err_clr),
    .starve_err (starve_err)
);

// File: tb/pp_sync_top_tb_top.sv
module pp_sync_top_tb_top;

    localparam int TW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          prod_done = 1'b0;
    logic          prod_sel;
    logic          prod_stall;
    logic          cons_req = 1'b0;
    logic          cons_latch;
    logic          cons_sel;
    logic [1:0]    buf_ready;
    logic [TW-1:0] wait_limit = '0;
    logic          err_clr = 1'b0;
    logic          starve_err;

    int total = 0;
    int bad   = 0;
    bit finished = 1'b0;

    // bench model state
    bit [1:0] m_flag;
    bit       m_ps;
    bit       m_cs;
    bit       m_err;
    int       m_wc;
    bit       m_held;

    always #5 clk = ~clk;

    pp_sync_top #(.TW(TW)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .prod_done  (prod_done),
        .prod_sel   (prod_sel),
        .prod_stall (prod_stall),
        .cons_req   (cons_req),
        .cons_latch (cons_latch),
        .cons_sel   (cons_sel),
        .buf_ready  (buf_ready),
        .wait_limit (wait_limit),
        .err_clr    (err_clr),
        .starve_err (starve_err)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        prod_done = 1'b0; cons_req = 1'b0; err_clr = 1'b0;
        m_flag = 2'b00; m_ps = 1'b0; m_cs = 1'b0; m_err = 1'b0; m_wc = 0; m_held = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
    endtask

    // One cycle: inputs are driven just after an edge, outputs compared 3 ns
    // later, the model advanced, then the next edge is awaited.
    task automatic cyc(input bit d, input bit r, input bit c, input bit full);
        bit stall;
        bit latch;
        bit waiting;
        bit acc;
        bit trip;
        int lim;
        prod_done = d; cons_req = r; err_clr = c;
        #3;
        lim     = int'(wait_limit);
        stall   = m_flag[m_ps];
        latch   = r && m_flag[m_cs];
        waiting = r && !m_flag[m_cs];
        chk("R4", "cons_latch", int'(cons_latch), int'(latch));
        chk("R7", "starve_err", int'(starve_err), int'(m_err));
        if (full) begin
            chk("R3", "prod_stall", int'(prod_stall), int'(stall));
            chk("R2", "prod_sel", int'(prod_sel), int'(m_ps));
            chk("R5", "cons_sel", int'(cons_sel), int'(m_cs));
            chk("R6", "buf_ready", int'(buf_ready), int'(m_flag));
        end
        acc  = d && !stall;
        trip = 1'b0;
        if (!waiting) begin
            m_wc = 0; m_held = 1'b0;
        end else if (lim != 0 && !m_held) begin
            m_wc++;
            if (m_wc == lim) begin trip = 1'b1; m_held = 1'b1; end
        end
        if (latch) m_flag[m_cs] = 1'b0;
        if (acc)   m_flag[m_ps] = 1'b1;
        if (acc)   m_ps = ~m_ps;
        if (latch) m_cs = ~m_cs;
        if (trip)       m_err = 1'b1;
        else if (c)     m_err = 1'b0;
        @(posedge clk);
        #1;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        int lims[5];
        lims = '{0, 1, 2, 3, 5};
        wait_limit = 4'd3;
        do_reset();
        #3;
        // R1 reset state
        chk("R1", "buf_ready", int'(buf_ready), 0);
        chk("R1", "prod_sel", int'(prod_sel), 0);
        chk("R1", "cons_sel", int'(cons_sel), 0);
        chk("R1", "prod_stall", int'(prod_stall), 0);
        chk("R1", "cons_latch", int'(cons_latch), 0);
        chk("R1", "starve_err", int'(starve_err), 0);
        @(posedge clk); #1;

        // R2/R6: two tiles back to back, both flags up, producer then stalls
        cyc(1, 0, 0, 1);
        cyc(1, 0, 0, 1);
        chk("R6", "both flags", int'(buf_ready), 3);
        chk("R3", "stall with both full", int'(prod_stall), 1);
        // R3: done while stalled ignored
        cyc(1, 0, 0, 1);
        chk("R3", "ignored done flags", int'(buf_ready), 3);
        chk("R3", "ignored done sel", int'(prod_sel), 0);
        // R5/R6: consumer takes buffer 0 then 1
        cyc(0, 1, 0, 1);
        chk("R5", "buf0 cleared", int'(buf_ready), 2);
        chk("R5", "cons_sel toggled", int'(cons_sel), 1);
        cyc(0, 1, 0, 1);
        chk("R6", "buf1 taken second", int'(buf_ready), 0);

        // R7: starve for exactly 3 cycles with limit 3
        cyc(0, 1, 0, 1);
        cyc(0, 1, 0, 1);
        chk("R7", "no error before limit", int'(starve_err), 0);
        cyc(0, 1, 0, 1);
        chk("R7", "error at limit", int'(starve_err), 1);
        // R9: clear during continued wait, no re-raise
        cyc(0, 1, 1, 1);
        cyc(0, 1, 0, 1);
        chk("R9", "no re-raise", int'(starve_err), 0);
        // R8: interrupted waits of 2 do not add up
        cyc(0, 0, 0, 1);
        cyc(0, 1, 0, 1); cyc(0, 1, 0, 1); cyc(0, 0, 0, 1);
        cyc(0, 1, 0, 1); cyc(0, 1, 0, 1);
        chk("R8", "no accumulation", int'(starve_err), 0);
        // R9: limit hit with clear in the same cycle keeps the error
        cyc(0, 1, 1, 1);
        chk("R9", "trip beats clear", int'(starve_err), 1);
        cyc(1, 0, 1, 1);
        chk("R9", "cleared", int'(starve_err), 0);

        // sweep over limits and all 4-cycle input patterns
        foreach (lims[k]) begin
            wait_limit = TW'(lims[k]);
            do_reset();
            #1;
            for (int s = 0; s < 256; s++) begin
                for (int j = 0; j < 4; j++) begin
                    cyc(s[2*j], s[2*j+1], ((total % 7) == 0), 1);
                end
            end
        end

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule